// File: doc/BRIEF.md
# Reconfigurable 2-D Inverse Integer Transform (4/8-point)

This block computes the two-dimensional inverse integer transform of one 8x8 region of a video decoder's residual data. Every region has one partition type: one 8x8 block, two 8-wide by 4-tall blocks stacked vertically, two 4-wide by 8-tall blocks side by side, or four 4x4 blocks. A single one-dimensional kernel serves every partition. It runs either as one 8-point transform or as two independent 4-point transforms on the two halves of its 8-element input. Every constant multiplication is built from shifts and adds, and one add/subtract butterfly stage is shared by both modes.

A region enters as eight coefficient rows, one row per accepted cycle. The row results go into a register transpose stage. The same kernel then runs eight column passes, one per cycle, and each column pass sends out one column of clipped residuals. A region takes 16 cycles when its rows arrive back to back. The input is refused while the column passes run.

Top module: `itx_2d`

## Requirements
- R1: During and right after reset, `out_valid` is 0, `in_ready` is 1 and `out_data` is all zeros.
- R2: The type codes are 0 = 8 wide by 8 tall, 1 = 8 wide by 4 tall, 2 = 4 wide by 8 tall and 3 = 4 wide by 4 tall. The code is taken on the first accepted row of a region. Changes to `in_type` on the later rows of that region have no effect.
- R3: Row stage. Coefficient element k sits at `in_coef[12k+11:12k]`, signed. For each row, E[j] = (sum over k of D[k]·T[k][j] + 4) >> 3, using an arithmetic shift. For width 8, T is the 8-point basis: row 0 is all 12; row 1 is 16,15,9,4,-4,-9,-15,-16; row 2 is 16,6,-6,-16,-16,-6,6,16; row 3 is 15,-4,-16,-9,9,16,4,-15; row 4 is 12,-12,-12,12,12,-12,-12,12; row 5 is 9,-16,4,15,-15,-4,16,-9; row 6 is 6,-16,16,-6,-6,16,-16,6; row 7 is 4,-9,15,-16,16,-15,9,-4. For width 4, the 4-point basis (rows 17,17,17,17 / 22,10,-10,-22 / 17,-17,-17,17 / 10,-22,22,-10) is applied to elements 0..3 and to elements 4..7 separately. Results are held as 16-bit signed values.
- R4: Column stage. For each column c, R[i] = (sum over k of E[k][c]·T[k][i] + 64 + b_i) >> 7, using an arithmetic shift. For height 8 the 8-point basis is used and b_i = 1 for i = 4..7. For height 4 the 4-point basis is applied to rows 0..3 and rows 4..7 separately, with b_i = 0. Each result saturates to the 10-bit signed range -512..511.
- R5: In 4-point mode the two halves are independent. A coefficient in one half never changes results in the other half, neither left/right in the row stage nor top/bottom in the column stage.
- R6: Outputs are column-major. The k-th output vector is column k, for k = 0..7. Element i sits at `out_data[10i+9:10i]` and holds region row i.
- R7: After the eighth row is accepted, `in_ready` is 0 for the next eight cycles. `out_valid` is 0 in the first of those cycles and 1 in the seven that follow, and it also stays 1 in the cycle right after them. In that last output cycle `in_ready` is already 1, so a new region can start 16 cycles after the previous one began.
- R8: `in_valid` is ignored while `in_ready` is 0. Data offered then changes neither the current region nor the next one.
- R9: Rows are counted only on accepted cycles. Idle cycles between rows, with any data or type on the inputs, do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A coefficient row is offered |
| in_ready | output | 1 | A row can be accepted (row phase) |
| in_type | input | 2 | Partition type code, taken on the first row |
| in_coef | input | 96 | Eight signed 12-bit coefficients |
| out_valid | output | 1 | `out_data` holds one output column |
| out_data | output | 80 | Eight signed 10-bit residuals of one column |

## Verification
Each column result is due a fixed number of edges after the eighth row is accepted. Column 0 appears after the second edge and column k after edge k+2. The bench therefore lets eight edges pass one by one after the last row and samples each column at the falling edge that follows its registering edge. At those same falling edges it checks `in_ready` and `out_valid`, which shows the 16-cycle schedule. The expected values come from a plain matrix product of the requirement bases with the rounding rules, over every partition type, all 64 single-coefficient positions, saturating patterns and random regions.

// File: rtl/itx_pkg.sv
`timescale 1ns/1ps
package itx_pkg;
    localparam int NP     = 8;          // points per vector
    localparam int HP     = NP / 2;     // points per half in 4-point mode
    localparam int CW     = 12;         // coefficient width
    localparam int IW     = 16;         // intermediate (row result) width
    localparam int OW     = 10;         // residual width
    localparam int AW     = IW + 8;     // accumulation width
    localparam int IDXW   = $clog2(NP);
    localparam int ROW_SH = 3;
    localparam int COL_SH = 7;

    typedef logic signed [AW-1:0] acc_t;
    typedef logic signed [IW-1:0] mid_t;
    typedef logic signed [OW-1:0] res_t;

    typedef enum logic [1:0] {
        TX_8X8 = 2'd0,
        TX_8X4 = 2'd1,
        TX_4X8 = 2'd2,
        TX_4X4 = 2'd3
    } tx_type_e;

    typedef struct packed {
        logic            col_phase;
        logic            mode8;
        logic [IDXW-1:0] idx;
    } itx_ctl_t;

    function automatic logic wide8(tx_type_e t);
        return (t == TX_8X8) || (t == TX_8X4);
    endfunction

    function automatic logic tall8(tx_type_e t);
        return (t == TX_8X8) || (t == TX_4X8);
    endfunction

    // constant products as shift-add networks
    function automatic acc_t m4(acc_t v);  return v <<< 2;                          endfunction
    function automatic acc_t m6(acc_t v);  return (v <<< 2) + (v <<< 1);            endfunction
    function automatic acc_t m9(acc_t v);  return (v <<< 3) + v;                    endfunction
    function automatic acc_t m10(acc_t v); return (v <<< 3) + (v <<< 1);            endfunction
    function automatic acc_t m12(acc_t v); return (v <<< 3) + (v <<< 2);            endfunction
    function automatic acc_t m15(acc_t v); return (v <<< 4) - v;                    endfunction
    function automatic acc_t m16(acc_t v); return v <<< 4;                          endfunction
    function automatic acc_t m17(acc_t v); return (v <<< 4) + v;                    endfunction
    function automatic acc_t m22(acc_t v); return (v <<< 4) + (v <<< 2) + (v <<< 1); endfunction
endpackage

// File: rtl/itx_ctrl.sv
`timescale 1ns/1ps
module itx_ctrl
    import itx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  tx_type_e in_type,
    output logic     in_ready,
    output logic     take,
    output itx_ctl_t ctl
);
    localparam logic [IDXW-1:0] LAST = IDXW'(NP - 1);

    logic            col_phase;
    logic [IDXW-1:0] cnt;
    tx_type_e        type_q;
    tx_type_e        cur_type;

    assign in_ready = !col_phase;
    assign take     = in_valid && in_ready;
    assign cur_type = (cnt == '0) ? in_type : type_q;

    always_comb begin
        ctl.col_phase = col_phase;
        ctl.idx       = cnt;
        ctl.mode8     = col_phase ? tall8(type_q) : wide8(cur_type);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_phase <= 1'b0;
            cnt       <= '0;
            type_q    <= TX_8X8;
        end else if (col_phase) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) col_phase <= 1'b0;
        end else if (take) begin
            if (cnt == '0) type_q <= in_type;
            cnt <= cnt + 1'b1;
            if (cnt == LAST) col_phase <= 1'b1;
        end
    end

    // R2
    type_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 || col_phase) |=> $stable(type_q));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!col_phase && !in_valid) |=> ($stable(cnt) && !col_phase));

    // R7
    phase_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (take && cnt == LAST) |=> (col_phase && cnt == '0));

    // R7
    phase_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (col_phase && cnt == LAST) |=> (in_ready && cnt == '0));
endmodule

// File: rtl/itx_kernel.sv
`timescale 1ns/1ps
module itx_kernel
    import itx_pkg::*;
(
    input  acc_t x [NP],
    input  logic mode8,
    output acc_t y [NP]
);
    localparam int LANES = HP;

    acc_t pre_s, pre_d, ka_s, ka_d;
    acc_t t2, t3;
    acc_t ca, da, ab, bb, cb, db;
    acc_t o0, o1, o2, o3;
    acc_t p [LANES];
    acc_t q [LANES];
    acc_t s [LANES];
    acc_t d [LANES];

    // shared pre-adder: x0 with x4 (8-point) or x2 (4-point, left half)
    always_comb begin
        pre_s = x[0] + (mode8 ? x[4] : x[2]);
        pre_d = x[0] - (mode8 ? x[4] : x[2]);
        ka_s  = mode8 ? m12(pre_s) : m17(pre_s);
        ka_d  = mode8 ? m12(pre_d) : m17(pre_d);
    end

    // 8-point even remainder and odd part
    always_comb begin
        t2 = m16(x[2]) + m6(x[6]);
        t3 = m6(x[2])  - m16(x[6]);
        o0 = m16(x[1]) + m15(x[3]) + m9(x[5])  + m4(x[7]);
        o1 = m15(x[1]) - m4(x[3])  - m16(x[5]) - m9(x[7]);
        o2 = m9(x[1])  - m16(x[3]) + m4(x[5])  + m15(x[7]);
        o3 = m4(x[1])  - m9(x[3])  + m15(x[5]) - m16(x[7]);
    end

    // 4-point terms of both halves
    always_comb begin
        ca = m22(x[1]) + m10(x[3]);
        da = m10(x[1]) - m22(x[3]);
        ab = m17(x[4] + x[6]);
        bb = m17(x[4] - x[6]);
        cb = m22(x[5]) + m10(x[7]);
        db = m10(x[5]) - m22(x[7]);
    end

    // lane operands
    always_comb begin
        if (mode8) begin
            p[0] = ka_s + t2;  q[0] = o0;
            p[1] = ka_d + t3;  q[1] = o1;
            p[2] = ka_d - t3;  q[2] = o2;
            p[3] = ka_s - t2;  q[3] = o3;
        end else begin
            p[0] = ka_s;       q[0] = ca;
            p[1] = ka_d;       q[1] = da;
            p[2] = ab;         q[2] = cb;
            p[3] = bb;         q[3] = db;
        end
    end

    // shared butterfly lanes
    for (genvar l = 0; l < LANES; l++) begin : g_bfly
        assign s[l] = p[l] + q[l];
        assign d[l] = p[l] - q[l];
    end

    // output placement per mode
    always_comb begin
        for (int i = 0; i < NP; i++) y[i] = '0;
        for (int l = 0; l < LANES; l++) begin
            if (mode8) begin
                y[l]          = s[l];
                y[NP - 1 - l] = d[l];
            end else begin
                y[(l / 2) * HP + (l % 2)]          = s[l];
                y[(l / 2) * HP + HP - 1 - (l % 2)] = d[l];
            end
        end
    end
endmodule

// File: rtl/itx_scale.sv
`timescale 1ns/1ps
module itx_scale
    import itx_pkg::*;
(
    input  acc_t y [NP],
    input  logic col8,
    output mid_t row_o [NP],
    output res_t col_o [NP]
);
    localparam acc_t ROW_RND = acc_t'(1 <<< (ROW_SH - 1));
    localparam acc_t COL_RND = acc_t'(1 <<< (COL_SH - 1));
    localparam acc_t OMAX    = acc_t'((1 <<< (OW - 1)) - 1);
    localparam acc_t OMIN    = acc_t'(-(1 <<< (OW - 1)));

    for (genvar i = 0; i < NP; i++) begin : g_lane
        acc_t rr, cr, bias;
        always_comb begin
            rr       = (y[i] + ROW_RND) >>> ROW_SH;
            row_o[i] = rr[IW-1:0];
            bias     = (col8 && i >= HP) ? acc_t'(1) : acc_t'(0);
            cr       = (y[i] + COL_RND + bias) >>> COL_SH;
            if (cr > OMAX)      col_o[i] = OMAX[OW-1:0];
            else if (cr < OMIN) col_o[i] = OMIN[OW-1:0];
            else                col_o[i] = cr[OW-1:0];
        end
    end
endmodule

// File: rtl/itx_2d.sv
`timescale 1ns/1ps
module itx_2d
    import itx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_type,
    input  logic [NP*CW-1:0]   in_coef,
    output logic               out_valid,
    output logic [NP*OW-1:0]   out_data
);
    localparam acc_t ROW_HI = acc_t'(((1 <<< (IW - 1)) - 1) <<< ROW_SH);
    localparam acc_t ROW_LO = acc_t'(-(1 <<< (IW - 1 + ROW_SH)));

    logic     take;
    itx_ctl_t ctl;
    acc_t     kin  [NP];
    acc_t     kout [NP];
    mid_t     row_o [NP];
    res_t     col_o [NP];
    mid_t     tbuf [NP][NP];

    itx_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_type  (tx_type_e'(in_type)),
        .in_ready (in_ready),
        .take     (take),
        .ctl      (ctl)
    );

    // kernel input: coefficient row or a transpose-stage column
    always_comb begin
        for (int k = 0; k < NP; k++) begin
            if (ctl.col_phase) kin[k] = acc_t'(tbuf[k][ctl.idx]);
            else               kin[k] = acc_t'($signed(in_coef[k*CW +: CW]));
        end
    end

    itx_kernel u_kernel (
        .x     (kin),
        .mode8 (ctl.mode8),
        .y     (kout)
    );

    itx_scale u_scale (
        .y     (kout),
        .col8  (ctl.mode8),
        .row_o (row_o),
        .col_o (col_o)
    );

    always_ff @(posedge clk) begin
        if (take) begin
            for (int k = 0; k < NP; k++) tbuf[ctl.idx][k] <= row_o[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctl.col_phase;
            if (ctl.col_phase) begin
                for (int k = 0; k < NP; k++) out_data[k*OW +: OW] <= col_o[k];
            end
        end
    end

    // R7
    out_after_col_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(!in_ready));

    // R8
    no_load_in_col_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |-> !take);

    for (genvar i = 0; i < NP; i++) begin : g_fit
        // R3
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            take |-> (kout[i] <= ROW_HI && kout[i] >= ROW_LO));
    end
endmodule

// File: tb/tb_itx_2d.sv
`timescale 1ns/1ps
module tb_itx_2d;
    localparam int NP = 8;
    localparam int CW = 12;
    localparam int OW = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [1:0]        in_type = 2'd0;
    logic [NP*CW-1:0]  in_coef = '0;
    logic              out_valid;
    logic [NP*OW-1:0]  out_data;

    int n_tests = 0;
    int n_fail  = 0;

    int D [8][8];
    int E [8][8];
    int R [8][8];

    int T8 [64] = '{12, 12, 12, 12, 12, 12, 12, 12,
                    16, 15,  9,  4, -4, -9,-15,-16,
                    16,  6, -6,-16,-16, -6,  6, 16,
                    15, -4,-16, -9,  9, 16,  4,-15,
                    12,-12,-12, 12, 12,-12,-12, 12,
                     9,-16,  4, 15,-15, -4, 16, -9,
                     6,-16, 16, -6, -6, 16,-16,  6,
                     4, -9, 15,-16, 16,-15,  9, -4};
    int T4 [16] = '{17, 17, 17, 17,
                    22, 10,-10,-22,
                    17,-17,-17, 17,
                    10,-22, 22,-10};

    itx_2d dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_type(in_type), .in_coef(in_coef), .out_valid(out_valid), .out_data(out_data)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit w8(int t); return t == 0 || t == 1; endfunction
    function automatic bit h8(int t); return t == 0 || t == 2; endfunction

    // behavioural matrix product with the rounding rules of R3 and R4
    task automatic model(input int t);
        for (int r = 0; r < 8; r++)
            for (int j = 0; j < 8; j++) begin
                int s = 0;
                if (w8(t)) for (int k = 0; k < 8; k++) s += D[r][k] * T8[k*8 + j];
                else       for (int k = 0; k < 4; k++) s += D[r][(j/4)*4 + k] * T4[k*4 + j%4];
                E[r][j] = (s + 4) >>> 3;
            end
        for (int c = 0; c < 8; c++)
            for (int i = 0; i < 8; i++) begin
                int s = 0;
                if (h8(t)) begin
                    for (int k = 0; k < 8; k++) s += E[k][c] * T8[k*8 + i];
                    s += 64 + ((i >= 4) ? 1 : 0);
                end else begin
                    for (int k = 0; k < 4; k++) s += E[(i/4)*4 + k][c] * T4[k*4 + i%4];
                    s += 64;
                end
                s = s >>> 7;
                R[i][c] = (s > 511) ? 511 : (s < -512) ? -512 : s;
            end
    endtask

    function automatic logic [NP*CW-1:0] pack_row(int r);
        logic [NP*CW-1:0] v;
        for (int k = 0; k < 8; k++) v[k*CW +: CW] = CW'(D[r][k]);
        return v;
    endfunction

    // chg: vary in_type after row 0 (R2); gap: idle cycles between rows (R9);
    // junk: offer data while not ready (R8)
    task automatic run_region(input int t, input bit chg, input bit gap, input bit junk, input string tag);
        model(t);
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            check(in_ready === 1'b1, "R7 ready in row phase", int'(in_ready), 1);
            in_valid = 1'b1;
            in_coef  = pack_row(r);
            in_type  = (r != 0 && chg) ? 2'(t + 1 + r) : 2'(t);
            @(posedge clk);
            if (gap && r < 7) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_coef  = {NP{12'h5A5}};
                in_type  = 2'(t + 2);
                @(posedge clk);
            end
        end
        @(negedge clk);
        in_valid = junk;
        in_coef  = {NP{12'h7FF}};
        in_type  = 2'(t + 1);
        check(in_ready === 1'b0 && out_valid === 1'b0, "R7 first column cycle",
              int'({in_ready, out_valid}), 0);
        for (int c = 0; c < 8; c++) begin
            bit ok = 1'b1;
            int bad_a = 0, bad_e = 0;
            @(posedge clk);
            @(negedge clk);
            check(out_valid === 1'b1, "R7 out_valid on column", int'(out_valid), 1);
            check(in_ready === (c == 7), "R7 ready at end of region", int'(in_ready), int'(c == 7));
            for (int i = 0; i < 8; i++) begin
                int got = int'($signed(out_data[i*OW +: OW]));
                if (got != R[i][c] && ok) begin
                    ok = 1'b0; bad_a = got; bad_e = R[i][c];
                end
            end
            // R3 R4 R5 R6 values, column c
            check(ok, tag, bad_a, bad_e);
            in_valid = (c < 6) ? junk : 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R7 out_valid drops", int'(out_valid), 0);
    endtask

    task automatic clear_d();
        for (int r = 0; r < 8; r++) for (int k = 0; k < 8; k++) D[r][k] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state while held
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1 reset flags", int'({out_valid, in_ready}), 1);
        rst = 1'b0;
        @(negedge clk);
        check(out_data === '0, "R1 reset data", int'(out_data[31:0]), 0);
        check(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        for (int t = 0; t < 4; t++) begin
            clear_d();
            run_region(t, 0, 0, 0, "R3 R4 zero region");
            D[0][0] = 2047;
            run_region(t, 0, 0, 0, "R3 R4 DC region");
            for (int r = 0; r < 8; r++) for (int k = 0; k < 8; k++) D[r][k] = -2048;
            run_region(t, 0, 0, 0, "R4 saturation low/high");
            for (int r = 0; r < 8; r++) for (int k = 0; k < 8; k++) D[r][k] = ((r + k) % 2) ? -2047 : 2047;
            run_region(t, 0, 0, 0, "R4 checkerboard saturation");
            for (int p = 0; p < 64; p++) begin
                clear_d();
                D[p/8][p%8] = (p % 2) ? -777 : 1234;
                run_region(t, 0, 0, 0, "R5 R6 single coefficient");
            end
            for (int n = 0; n < 12; n++) begin
                for (int r = 0; r < 8; r++) for (int k = 0; k < 8; k++)
                    D[r][k] = (n < 6) ? int'($urandom_range(4095)) - 2048
                                      : int'($urandom_range(255)) - 128;
                run_region(t, n % 3 == 0, n % 3 == 1, n % 2 == 0, "R2 R8 R9 random region");
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule